// File: doc/BRIEF.md
# Delay Window Centering Unit

This block sits at the end of a per-lane delay training flow. For each byte lane it receives a signed low limit and a signed high limit. Together they bound the passing window of a delay line with taps 0 to 31. The unit runs in two steps, each started by a strobe.

On `start` it decides which lanes need an extra search to extend a window edge. Only narrow windows qualify, and only when they sit against tap 0 or tap 31; this check runs in receive mode only. The two lane masks that result go to an external search engine. That engine may rewrite the limits.

On `resume` the unit takes the limits present at its inputs and computes each lane's midpoint. It clamps the midpoint into the tap range. In transmit mode it then adds the lane's write-leveling offset. The final taps are registered and marked by a one-cycle valid pulse.

Top module: `window_center_unit`

## Requirements
- R1: With `txMode` low at a `start`, bit i of `lowSearchMask` is set exactly when lane i's signed width (high minus low) is below `WIN_THRESH` and its low limit equals 0.
- R2: With `txMode` low at a `start`, bit i of `highSearchMask` is set exactly when lane i's signed width is below `WIN_THRESH` and its high limit equals the top tap (31).
- R3: With `txMode` high at a `start`, both search masks become all zero.
- R4: `flagsValid` is high for exactly the one cycle after a cycle with `start` high. The masks change only on that edge and otherwise hold.
- R5: On `resume`, each lane's midpoint is the signed sum of its high and low limits divided by 2, rounded toward zero.
- R6: A midpoint below 0 becomes 0, and a midpoint above 31 becomes 31.
- R7: With `txMode` low at a `resume`, the tap is the clamped midpoint. With `txMode` high, it is the clamped midpoint plus the lane's offset, taken modulo 32.
- R8: `tapsValid` is high for exactly the one cycle after a cycle with `resume` high. The taps change only on that edge and otherwise hold.
- R9: Lane i occupies bits [i*W +: W] of every packed per-lane bus, where W is that bus's field width. Mask bit i belongs to lane i. After reset, masks, taps and both valid outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the limits and compute the search masks |
| resume | input | 1 | Capture the limits and compute the final taps |
| txMode | input | 1 | 1 = transmit-side training, 0 = receive-side training |
| lowLimits | input | NUM_LANES*LIMIT_W | Signed low window limit per lane |
| highLimits | input | NUM_LANES*LIMIT_W | Signed high window limit per lane |
| wlOffsets | input | NUM_LANES*TAP_W | Unsigned write-leveling offset per lane |
| lowSearchMask | output | NUM_LANES | Lanes that need a low-edge extension search |
| highSearchMask | output | NUM_LANES | Lanes that need a high-edge extension search |
| flagsValid | output | 1 | One-cycle pulse: the masks were just updated |
| taps | output | NUM_LANES*TAP_W | Final tap per lane |
| tapsValid | output | 1 | One-cycle pulse: the taps were just updated |

## Verification
The assertions assume that `start` and `resume` are single-cycle pulses sampled at a clock edge. They also assume that `txMode`, the limits and the offsets are steady at the edge where a strobe is taken; between strobes these inputs may change freely. The bench changes inputs only on falling edges and raises each strobe for exactly one cycle. It applies the two strobes in separate cycles. Limits stay within ±40, so sums and widths never approach the signed range of the limit fields. One step moves the limits while no strobe is present, to show that the held outputs do not follow them.

// File: rtl/wcu_pkg.sv
package wcu_pkg;
  typedef struct packed {
    logic captureFlags;
    logic captureTaps;
  } ctrlStrobes_t;
endpackage

// File: rtl/wcu_ctrl.sv
module wcu_ctrl
  import wcu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         resume,
  output ctrlStrobes_t strobes,
  output logic         flagsValid,
  output logic         tapsValid
);
  assign strobes.captureFlags = start;
  assign strobes.captureTaps  = resume;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsValid <= 1'b0;
      tapsValid  <= 1'b0;
    end else begin
      flagsValid <= start;
      tapsValid  <= resume;
    end
  end
endmodule

// File: rtl/wcu_datapath.sv
module wcu_datapath
  import wcu_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LIMIT_W    = 8,
  parameter int TAP_W      = 5,
  parameter int WIN_THRESH = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic                       txMode,
  input  logic [NUM_LANES*LIMIT_W-1:0] lowLimits,
  input  logic [NUM_LANES*LIMIT_W-1:0] highLimits,
  input  logic [NUM_LANES*TAP_W-1:0]   wlOffsets,
  output logic [NUM_LANES-1:0]         lowSearchMask,
  output logic [NUM_LANES-1:0]         highSearchMask,
  output logic [NUM_LANES*TAP_W-1:0]   taps
);
  localparam int EXT_W   = LIMIT_W + 1;
  localparam int TAP_MAX = (1 << TAP_W) - 1;
  localparam logic signed [EXT_W-1:0] TAP_MAX_S = EXT_W'(TAP_MAX);
  localparam logic signed [EXT_W-1:0] THRESH_S  = EXT_W'(WIN_THRESH);

  logic             lowReg  [NUM_LANES];
  logic             highReg [NUM_LANES];
  logic [TAP_W-1:0] tapReg  [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LIMIT_W-1:0]      loRaw, hiRaw;
    logic signed [EXT_W-1:0] loExt, hiExt, width, sum, half;
    logic [TAP_W-1:0]        clampTap, wl, finalTap;
    logic                    narrow, needLow, needHigh;

    assign loRaw = lowLimits[g*LIMIT_W +: LIMIT_W];
    assign hiRaw = highLimits[g*LIMIT_W +: LIMIT_W];
    assign wl    = wlOffsets[g*TAP_W +: TAP_W];
    assign loExt = $signed({loRaw[LIMIT_W-1], loRaw});
    assign hiExt = $signed({hiRaw[LIMIT_W-1], hiRaw});

    assign width    = hiExt - loExt;
    assign narrow   = width < THRESH_S;
    assign needLow  = !txMode && narrow && (loExt == '0);
    assign needHigh = !txMode && narrow && (hiExt == TAP_MAX_S);

    // signed halving rounded toward zero: bias odd negative sums by one
    assign sum  = hiExt + loExt;
    assign half = (sum + $signed({{(EXT_W-1){1'b0}}, sum[EXT_W-1]})) >>> 1;

    always_comb begin
      if (half < 0)              clampTap = '0;
      else if (half > TAP_MAX_S) clampTap = TAP_W'(TAP_MAX);
      else                       clampTap = half[TAP_W-1:0];
    end

    assign finalTap = txMode ? clampTap + wl : clampTap;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowReg[g]  <= 1'b0;
        highReg[g] <= 1'b0;
      end else if (strobes.captureFlags) begin
        lowReg[g]  <= needLow;
        highReg[g] <= needHigh;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    tapReg[g] <= '0;
      else if (strobes.captureTaps) tapReg[g] <= finalTap;
    end

    assign lowSearchMask[g]            = lowReg[g];
    assign highSearchMask[g]           = highReg[g];
    assign taps[g*TAP_W +: TAP_W]      = tapReg[g];
  end
endmodule

// File: rtl/window_center_unit.sv
module window_center_unit
  import wcu_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LIMIT_W    = 8,
  parameter int TAP_W      = 5,
  parameter int WIN_THRESH = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         resume,
  input  logic                         txMode,
  input  logic [NUM_LANES*LIMIT_W-1:0] lowLimits,
  input  logic [NUM_LANES*LIMIT_W-1:0] highLimits,
  input  logic [NUM_LANES*TAP_W-1:0]   wlOffsets,
  output logic [NUM_LANES-1:0]         lowSearchMask,
  output logic [NUM_LANES-1:0]         highSearchMask,
  output logic                         flagsValid,
  output logic [NUM_LANES*TAP_W-1:0]   taps,
  output logic                         tapsValid
);
  ctrlStrobes_t strobes;

  wcu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume),
    .strobes(strobes), .flagsValid(flagsValid), .tapsValid(tapsValid)
  );

  wcu_datapath #(
    .NUM_LANES(NUM_LANES), .LIMIT_W(LIMIT_W),
    .TAP_W(TAP_W), .WIN_THRESH(WIN_THRESH)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txMode(txMode),
    .lowLimits(lowLimits), .highLimits(highLimits), .wlOffsets(wlOffsets),
    .lowSearchMask(lowSearchMask), .highSearchMask(highSearchMask),
    .taps(taps)
  );
endmodule

// File: rtl/wcu_checker.sv
module wcu_checker #(
  parameter int NUM_LANES = 4,
  parameter int TAP_W     = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       resume,
  input logic                       txMode,
  input logic [NUM_LANES-1:0]       lowSearchMask,
  input logic [NUM_LANES-1:0]       highSearchMask,
  input logic                       flagsValid,
  input logic [NUM_LANES*TAP_W-1:0] taps,
  input logic                       tapsValid
);
  assert_flags_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    start |=> flagsValid);
  assert_flags_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !flagsValid);
  assert_masks_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(lowSearchMask) && $stable(highSearchMask)));
  assert_tx_no_search_R3: assert property (@(posedge clk) disable iff (!rstN)
    (start && txMode) |=> (lowSearchMask == '0 && highSearchMask == '0));
  assert_taps_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resume |=> tapsValid);
  assert_taps_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resume |=> !tapsValid);
  assert_taps_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resume |=> $stable(taps));
endmodule

bind window_center_unit wcu_checker #(.NUM_LANES(NUM_LANES), .TAP_W(TAP_W)) u_wcu_checker (
  .clk(clk), .rstN(rstN), .start(start), .resume(resume), .txMode(txMode),
  .lowSearchMask(lowSearchMask), .highSearchMask(highSearchMask),
  .flagsValid(flagsValid), .taps(taps), .tapsValid(tapsValid)
);

// File: tb/window_center_unit_bench.sv
module window_center_unit_bench;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int TW = 5;
  localparam int TH = 7;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, resume = 1'b0, txMode = 1'b0;
  logic [NL*LW-1:0] lowLimits = '0, highLimits = '0;
  logic [NL*TW-1:0] wlOffsets = '0;
  logic [NL-1:0] lowSearchMask, highSearchMask;
  logic flagsValid, tapsValid;
  logic [NL*TW-1:0] taps;

  int errors = 0;
  int checks = 0;
  int vals [NV] = '{-20, -5, -1, 0, 1, 3, 6, 10, 24, 28, 30, 31, 32, 40};
  int loV [NL], hiV [NL], wlV [NL];

  always #2.5 clk = ~clk;

  window_center_unit #(.NUM_LANES(NL), .LIMIT_W(LW), .TAP_W(TW), .WIN_THRESH(TH))
    u_window_center_unit (
      .clk(clk), .rstN(rstN), .start(start), .resume(resume), .txMode(txMode),
      .lowLimits(lowLimits), .highLimits(highLimits), .wlOffsets(wlOffsets),
      .lowSearchMask(lowSearchMask), .highSearchMask(highSearchMask),
      .flagsValid(flagsValid), .taps(taps), .tapsValid(tapsValid));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expTap(int lo, int hi, int wl, bit tx);
    int m;
    m = (lo + hi) / 2;
    if (m < 0) m = 0;
    if (m > 31) m = 31;
    if (tx) m = (m + wl) % 32;
    return m;
  endfunction

  task automatic drive();
    for (int l = 0; l < NL; l++) begin
      lowLimits[l*LW +: LW]  = LW'(loV[l]);
      highLimits[l*LW +: LW] = LW'(hiV[l]);
      wlOffsets[l*TW +: TW]  = TW'(wlV[l]);
    end
  endtask

  task automatic runRound(int r, bit tx);
    int p;
    bit eLo, eHi;
    for (int l = 0; l < NL; l++) begin
      p = (r * NL + l) % (NV * NV);
      loV[l] = vals[p / NV];
      hiV[l] = vals[p % NV];
      wlV[l] = (r * 7 + l * 11) % 32;
    end
    txMode = tx;
    drive();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(flagsValid == 1'b1, "R4 flagsValid pulse", flagsValid, 1);
    for (int l = 0; l < NL; l++) begin
      eLo = !tx && (hiV[l] - loV[l] < TH) && (loV[l] == 0);
      eHi = !tx && (hiV[l] - loV[l] < TH) && (hiV[l] == 31);
      if (tx) begin
        check(lowSearchMask[l] == 1'b0 && highSearchMask[l] == 1'b0,
              "R3 tx masks clear", {lowSearchMask[l], highSearchMask[l]}, 0);
      end else begin
        check(lowSearchMask[l] == eLo, "R1 low search flag", lowSearchMask[l], eLo);
        check(highSearchMask[l] == eHi, "R2 high search flag", highSearchMask[l], eHi);
      end
    end
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    check(flagsValid == 1'b0, "R4 flagsValid single cycle", flagsValid, 0);
    check(tapsValid == 1'b1, "R8 tapsValid pulse", tapsValid, 1);
    for (int l = 0; l < NL; l++) begin
      int e;
      e = expTap(loV[l], hiV[l], wlV[l], tx);
      check(int'(taps[l*TW +: TW]) == e,
            tx ? "R7 tx tap (R5 R6 R9)" : "R7 rx tap (R5 R6 R9)",
            int'(taps[l*TW +: TW]), e);
    end
    @(negedge clk);
    check(tapsValid == 1'b0, "R8 tapsValid single cycle", tapsValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(lowSearchMask == '0 && highSearchMask == '0, "R9 reset masks",
          int'({lowSearchMask, highSearchMask}), 0);
    check(taps == '0 && !flagsValid && !tapsValid, "R9 reset taps",
          int'(taps), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 49; r++) runRound(r, 1'b0);
    for (int r = 0; r < 49; r++) runRound(r, 1'b1);
    // R4/R8: held outputs do not follow input changes without a strobe
    txMode = 1'b0;
    for (int l = 0; l < NL; l++) begin loV[l] = 0; hiV[l] = 3; wlV[l] = 0; end
    drive();
    start = 1'b1; @(negedge clk); start = 1'b0;
    resume = 1'b1; @(negedge clk); resume = 1'b0;
    for (int l = 0; l < NL; l++) begin loV[l] = 10; hiV[l] = 30; end
    drive();
    repeat (3) @(negedge clk);
    check(lowSearchMask == '1, "R4 masks held", int'(lowSearchMask), 15);
    check(int'(taps[0 +: TW]) == 1, "R8 taps held", int'(taps[0 +: TW]), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule